// File: doc/BRIEF.md
# Rotated 8-bit immediate expander

The block turns a 12-bit immediate field into a 32-bit constant and a carry-out flag. The low byte of the field is the payload. The upper nibble is a rotation count. The byte is zero-extended to 32 bits and rotated right by twice that count, so only even amounts from 0 to 30 can occur. When the count is zero, the incoming carry passes through unchanged. Otherwise the carry-out is the top bit of the rotated constant.

Fields enter on a valid/ready stream and leave, one cycle later, on a second valid/ready stream that carries the constant and its carry. An item is transferred on a rising clock edge when valid and ready are both high. The output holds its item while the consumer keeps `out_ready` low. The input stream is back-pressured only when the output register is full and is not being drained in the same cycle. This allows one transfer per cycle at full throughput. Width of the byte, width of the count and width of the constant are parameters.

Top module: `rotimm_expander`

## Requirements
- R1: The payload byte is `in_field[7:0]` and the rotation count is `in_field[11:8]`. The constant equals the byte zero-extended to 32 bits and rotated right by 2 × count.
- R2: When the count is zero, the constant is the zero-extended byte with bits 31:8 all zero.
- R3: When the count is nonzero, `out_carry` equals bit 31 of the produced constant.
- R4: The rotation wraps around. A bit shifted out past bit 0 re-enters at bit 31, so count 1 places byte bits 1:0 in constant bits 31:30.
- R5: After reset `out_valid` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_value` and `out_carry` stay unchanged.
- R6: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. A field accepted on an edge shows up with `out_valid` 1 after that edge.
- R7: Every accepted field yields exactly one output item, and items leave in the order they were accepted.
- R8: When the count is zero, `out_carry` equals the `in_carry` that was accepted with the field, for both carry values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_field | input | 12 | Immediate field: count in 11:8, byte in 7:0 |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer takes the output item |
| out_value | output | 32 | Expanded 32-bit constant |
| out_carry | output | 1 | Carry-out flag |

## Verification
The bench applies all 4096 field values, each with carry-in 0 and carry-in 1, and compares them with an independently computed rotation.

- Count zero is checked with both carry values. A design that took the carry from bit 31 there would lose a set carry-in on every small byte.
- Counts that carry byte bits past bit 0 are included. A design that shifted instead of rotating would return zeros in the high bits.
- Odd byte patterns are checked at every count. A design that rotated by the count rather than twice it would miscompare on nearly all of them.
- A pseudo-random `out_ready` stalls the output at many points. A design that changed its output while stalled, or that dropped or duplicated an item under back-pressure, would break the hold checks or the in-order scoreboard.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_CNT_W  = 4;
  localparam int unsigned DEF_DATA_W = 32;

  // Largest rotation reachable with a given count width (amount is 2 x count).
  function automatic int unsigned max_rot(input int unsigned cnt_w);
    return 2 * ((1 << cnt_w) - 1);
  endfunction
endpackage

// File: rtl/rotimm_fixed_rot.sv
// Conditional rotate-right by a fixed amount: one stage of the log rotator.
module rotimm_fixed_rot #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH     = 2
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] rotated;
  assign rotated = {din[SH-1:0], din[DATA_W-1:SH]};
  assign dout    = en ? rotated : din;
endmodule

// File: rtl/rotimm_core.sv
// Combinational expansion: zero-extend the byte, rotate right by 2*count,
// select the carry.
module rotimm_core #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [CNT_W-1:0]  count,
  input  logic              carry_in,
  output logic [DATA_W-1:0] value,
  output logic              carry_out
);
  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = {{(DATA_W-BYTE_W){1'b0}}, byte_in};

  // Count bit k contributes a rotation of 2^(k+1) bit positions.
  for (genvar k = 0; k < CNT_W; k++) begin : g_rot
    rotimm_fixed_rot #(.DATA_W(DATA_W), .SH(2 << k)) u_rot (
      .en   (count[k]),
      .din  (stage[k]),
      .dout (stage[k+1])
    );
  end

  assign value     = stage[CNT_W];
  assign carry_out = (count == '0) ? carry_in : value[DATA_W-1];
endmodule

// File: rtl/rotimm_stage.sv
// One-entry valid/ready pipeline register that accepts while it is being drained.
module rotimm_stage #(
  parameter int unsigned W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (s_ready) vld_q <= s_valid;
      if (s_valid && s_ready) dat_q <= s_data;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (m_valid && m_data == $past(s_data)));
endmodule

// File: rtl/rotimm_expander.sv
module rotimm_expander
  import rotimm_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W+CNT_W-1:0] in_field,
  input  logic                    in_carry,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_value,
  output logic                    out_carry
);
  localparam int unsigned FIELD_W = BYTE_W + CNT_W;
  localparam int unsigned PAY_W   = DATA_W + 1;

  logic [BYTE_W-1:0] fld_byte;
  logic [CNT_W-1:0]  fld_cnt;
  logic [DATA_W-1:0] core_value;
  logic              core_carry;
  logic [PAY_W-1:0]  pay_out;

  assign fld_byte = in_field[BYTE_W-1:0];
  assign fld_cnt  = in_field[FIELD_W-1:BYTE_W];

  rotimm_core #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .byte_in   (fld_byte),
    .count     (fld_cnt),
    .carry_in  (in_carry),
    .value     (core_value),
    .carry_out (core_carry)
  );

  rotimm_stage #(.W(PAY_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  ({core_carry, core_value}),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign out_value = pay_out[DATA_W-1:0];
  assign out_carry = pay_out[DATA_W];

  initial begin
    assert (DATA_W > max_rot(CNT_W) && DATA_W >= BYTE_W)
      else $error("rotation range exceeds constant width");
  end

  // A rotation only moves bits: the number of ones is preserved.
  assert_popcount_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(core_value) == $countones(fld_byte)));

  assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fld_cnt == '0) |->
      (core_value == {{(DATA_W-BYTE_W){1'b0}}, fld_byte} && core_carry == in_carry));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fld_cnt == CNT_W'(1)) |->
      (core_value[DATA_W-1:DATA_W-2] == fld_byte[1:0]));
endmodule

// File: tb/sim_rotimm_expander.sv
`timescale 1ns/1ps
module sim_rotimm_expander;
  typedef struct {
    logic [11:0] field;
    logic        cin;
    logic [31:0] value;
    logic        carry;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_field = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_value;
  logic        out_carry;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_sent   = 0;
  int   n_recv   = 0;
  bit   done     = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  rotimm_expander u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_field(in_field), .in_carry(in_carry), .out_valid(out_valid),
    .out_ready(out_ready), .out_value(out_value), .out_carry(out_carry)
  );

  function automatic exp_t model(input logic [11:0] f, input logic c);
    exp_t e;
    logic [63:0] dbl;
    int rot;
    rot = 2 * int'(f[11:8]);
    dbl = {24'b0, f[7:0], 24'b0, f[7:0]};
    e.field = f;
    e.cin   = c;
    e.value = dbl[31:0];
    if (rot != 0) e.value = 32'(dbl >> rot);
    e.carry = (rot == 0) ? c : e.value[31];
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] f, input logic c);
    in_field = f;
    in_carry = c;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) begin
      @(posedge clk); #1;
      @(negedge clk);
    end
    sb.push_back(model(f, c));
    n_sent++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Back-pressure pattern from an LFSR.
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (lfsr[2:0] != 3'b000);
  end

  // Monitor: samples at the falling edge.
  logic        prev_stall = 1'b0;
  logic [32:0] prev_pay   = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 1'b0, "R5 reset", {32'b0, out_valid}, 33'd0);
    end else begin
      check(in_ready == (!out_valid || out_ready), "R6 ready rule",
            {32'b0, in_ready}, {32'b0, (!out_valid || out_ready)});
      if (prev_stall)
        check(out_valid && {out_carry, out_value} == prev_pay, "R5 hold",
              {out_carry, out_value}, prev_pay);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 unexpected item", {out_carry, out_value}, 33'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          n_recv++;
          if (e.field[11:8] == 4'd0)
            check({out_carry, out_value} == {e.carry, e.value}, "R2 R8 zero count",
                  {out_carry, out_value}, {e.carry, e.value});
          else if (e.field[11:8] == 4'd1)
            check({out_carry, out_value} == {e.carry, e.value}, "R4 R3 wrap",
                  {out_carry, out_value}, {e.carry, e.value});
          else
            check({out_carry, out_value} == {e.carry, e.value}, "R1 R3 rotation",
                  {out_carry, out_value}, {e.carry, e.value});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_pay   = {out_carry, out_value};
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // Directed corners first: R2/R8 carry pass, R4 wrap, R3 top-bit carry.
    send(12'h0FF, 1'b1);
    send(12'h001, 1'b0);
    send(12'h103, 1'b0);
    send(12'h102, 1'b1);
    send(12'hF80, 1'b0);
    // Exhaustive sweep over all fields with both carry values (R1).
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 4096; f++)
        send(12'(f), c[0]);
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    // R7: every accepted item came out, none left over.
    check(n_recv == n_sent && sb.size() == 0, "R7 count",
          33'(n_recv), 33'(n_sent));
    finish_run();
  end
endmodule